// File: doc/BRIEF.md
# Triple Bus Majority Voter

This block watches three copies of the same monitoring bus, one from each of three processors that run in lockstep. It builds a single trusted bus by taking the bitwise two-out-of-three majority of the lanes. For every lane it also emits a discrepancy vector that marks the bits where that lane disagrees with the voted result.

A resolver stage reduces each discrepancy vector to one reset-request line. The request names the processor that must be restarted. Restoring that processor's state and choosing when to act on the request are left to logic outside the block.

Each lane carries a field of processor-core signals placed above a field of system-bus signals. Both widths are parameters, and the voting itself treats every bit alike. All results are registered. A mismatch that lasts a single cycle therefore still yields a one-cycle request.

Top module: `tmr_bus_voter`

## Requirements
- R1: Each lane is CORE_W + SYS_W bits wide, 23 + 133 = 156 by default. The core field occupies bits [155:133] and the system-bus field occupies bits [132:0]. Every bit position is voted and compared on its own, in both fields.
- R2: Bit k of the voted bus equals (a AND b) OR (b AND c) OR (a AND c), where a, b and c are bit k of lanes 0, 1 and 2.
- R3: The voted bus, the three discrepancy vectors and the reset requests all change exactly one clock edge after the inputs they are computed from, and all of them together.
- R4: The discrepancy vector of lane i equals lane i XOR the voted bus, bit by bit.
- R5: Bit i of `req_reset` (bit 0 for lane 0, bit 1 for lane 1, bit 2 for lane 2) is 1 exactly when the discrepancy vector of lane i has at least one bit set.
- R6: A mismatch on one lane that is present for a single cycle raises that lane's request for exactly one cycle, and the request drops once the lanes agree again.
- R7: When the lanes disagree on different bits so that every lane is outvoted somewhere, all three request bits are raised together and no tie-breaking takes place.
- R8: While `rst` is high at a clock edge, every output is cleared to zero at that edge, whatever the inputs are.
- R9: When all three lanes are equal, the voted bus equals them, every discrepancy vector is zero and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are updated on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lane0_bus | input | 156 | Monitoring bus of processor 0 |
| lane1_bus | input | 156 | Monitoring bus of processor 1 |
| lane2_bus | input | 156 | Monitoring bus of processor 2 |
| voted_bus | output | 156 | Registered bitwise majority of the three lanes |
| lane0_diff | output | 156 | Registered lane 0 XOR majority |
| lane1_diff | output | 156 | Registered lane 1 XOR majority |
| lane2_diff | output | 156 | Registered lane 2 XOR majority |
| req_reset | output | 3 | Registered per-processor reset requests, bit i for lane i |

## Verification
Every result of the block is due on the first rising edge after the inputs that produce it, and all results arrive together. The bench therefore changes the inputs on falling edges. Its reference model takes in the inputs at each rising edge, and the outputs are compared with the model at the next falling edge, so each comparison sees the results of exactly one input set.

Directed checks work on the same edge arithmetic. A one-cycle glitch is looked for at the falling edge after its rising edge, and is expected to be gone one cycle later. A fresh input applied on a falling edge must not yet be visible at that falling edge.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

  // Default field widths of one monitoring lane
  localparam int DEF_CORE_W = 23;
  localparam int DEF_SYS_W  = 133;
  localparam int N_LANES    = 3;

  // Two-out-of-three majority of one bit position
  function automatic logic maj_bit(input logic a, input logic b, input logic c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  // A lane disagrees with the vote at one bit position
  function automatic logic miss_bit(input logic lane, input logic vote);
    return lane ^ vote;
  endfunction

endpackage

// File: rtl/tmr_maj_voter.sv
module tmr_maj_voter
  import tmr_vote_pkg::*;
#(
  parameter int W = 156
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] vote
);

  // One independent voter per bit position
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign vote[k] = maj_bit(in_a[k], in_b[k], in_c[k]);
  end

endmodule

// File: rtl/tmr_lane_compare.sv
module tmr_lane_compare
  import tmr_vote_pkg::*;
#(
  parameter int W = 156
) (
  input  logic [W-1:0] lane,
  input  logic [W-1:0] vote,
  output logic [W-1:0] diff,
  output logic         nonzero
);

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign diff[k] = miss_bit(lane[k], vote[k]);
  end

  assign nonzero = |diff;

endmodule

// File: rtl/tmr_reset_resolver.sv
module tmr_reset_resolver #(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_bad,
  output logic [LANES-1:0] req
);

  always_ff @(posedge clk) begin
    if (rst) req <= '0;
    else     req <= lane_bad;
  end

  // R5 / R6: a lane flagged in one cycle is requested in the next, and only then
  a_r5_req_tracks_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (req == $past(lane_bad)));

  // R8: reset clears every request
  a_r8_req_cleared: assert property (@(posedge clk)
    rst |=> (req == '0));

endmodule

// File: rtl/tmr_bus_voter.sv
module tmr_bus_voter
  import tmr_vote_pkg::*;
#(
  parameter int CORE_W = DEF_CORE_W,
  parameter int SYS_W  = DEF_SYS_W,
  localparam int BUS_W = CORE_W + SYS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] lane0_bus,
  input  logic [BUS_W-1:0] lane1_bus,
  input  logic [BUS_W-1:0] lane2_bus,
  output logic [BUS_W-1:0] voted_bus,
  output logic [BUS_W-1:0] lane0_diff,
  output logic [BUS_W-1:0] lane1_diff,
  output logic [BUS_W-1:0] lane2_diff,
  output logic [2:0]       req_reset
);

  // Named internal events
  logic [BUS_W-1:0]   lane_in [N_LANES];
  logic [BUS_W-1:0]   vote_c;
  logic [BUS_W-1:0]   diff_c  [N_LANES];
  logic [N_LANES-1:0] lane_bad_c;
  logic [BUS_W-1:0]   diff_q  [N_LANES];
  logic               all_agree_c;

  assign lane_in[0] = lane0_bus;
  assign lane_in[1] = lane1_bus;
  assign lane_in[2] = lane2_bus;

  tmr_maj_voter #(.W(BUS_W)) u_voter (
    .in_a (lane0_bus),
    .in_b (lane1_bus),
    .in_c (lane2_bus),
    .vote (vote_c)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    tmr_lane_compare #(.W(BUS_W)) u_cmp (
      .lane    (lane_in[g]),
      .vote    (vote_c),
      .diff    (diff_c[g]),
      .nonzero (lane_bad_c[g])
    );

    always_ff @(posedge clk) begin
      if (rst) diff_q[g] <= '0;
      else     diff_q[g] <= diff_c[g];
    end
  end

  assign all_agree_c = (lane0_bus == lane1_bus) && (lane1_bus == lane2_bus);

  always_ff @(posedge clk) begin
    if (rst) voted_bus <= '0;
    else     voted_bus <= vote_c;
  end

  assign lane0_diff = diff_q[0];
  assign lane1_diff = diff_q[1];
  assign lane2_diff = diff_q[2];

  tmr_reset_resolver #(.LANES(N_LANES)) u_resolver (
    .clk      (clk),
    .rst      (rst),
    .lane_bad (lane_bad_c),
    .req      (req_reset)
  );

  // R2 / R3: two equal lanes outvote the third, one cycle later
  a_r2_pair_wins: assert property (@(posedge clk) disable iff (rst)
    (lane0_bus == lane1_bus) |=> (voted_bus == $past(lane0_bus)));

  // R4: each registered report rebuilds its lane from the vote
  a_r4_diff_rebuilds_lane: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((voted_bus ^ lane0_diff) == $past(lane0_bus)) &&
              ((voted_bus ^ lane1_diff) == $past(lane1_bus)) &&
              ((voted_bus ^ lane2_diff) == $past(lane2_bus))));

  // R5: the request lines agree with the registered reports
  a_r5_req_matches_diff: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (req_reset == {|lane2_diff, |lane1_diff, |lane0_diff}));

  // R5 / R6: a lone outvoted lane 0 is the only one named
  a_r5_lone_fault: assert property (@(posedge clk) disable iff (rst)
    ((lane1_bus == lane2_bus) && (lane0_bus != lane1_bus)) |=> (req_reset == 3'b001));

  // R9: full agreement gives no report and no request
  a_r9_quiet_when_equal: assert property (@(posedge clk) disable iff (rst)
    all_agree_c |=> ((req_reset == 3'b000) && (lane0_diff == '0) &&
                     (lane1_diff == '0) && (lane2_diff == '0)));

  // R8: reset clears the bus outputs
  a_r8_outputs_cleared: assert property (@(posedge clk)
    rst |=> ((voted_bus == '0) && (lane0_diff == '0) &&
             (lane1_diff == '0) && (lane2_diff == '0)));

endmodule

// File: tb/sim_tmr_bus_voter.sv
`timescale 1ns/1ps
module sim_tmr_bus_voter;

  localparam int W = 156;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] l0 = '0, l1 = '0, l2 = '0;
  logic [W-1:0] voted, d0, d1, d2;
  logic [2:0]   req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit armed = 1'b0;

  // Reference model state
  logic [W-1:0] m_vote = '0, m_d0 = '0, m_d1 = '0, m_d2 = '0;
  logic [2:0]   m_req = '0;

  always #10 clk = ~clk;

  tmr_bus_voter u0 (
    .clk(clk), .rst(rst),
    .lane0_bus(l0), .lane1_bus(l1), .lane2_bus(l2),
    .voted_bus(voted), .lane0_diff(d0), .lane1_diff(d1), .lane2_diff(d2),
    .req_reset(req)
  );

  function automatic logic [W-1:0] ref_vote(input logic [W-1:0] a, b, c);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) begin
      int ones;
      ones = int'(a[k]) + int'(b[k]) + int'(c[k]);
      r[k] = (ones >= 2);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_diff(input logic [W-1:0] x, v);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = (x[k] != v[k]);
    return r;
  endfunction

  function automatic logic any_set(input logic [W-1:0] x);
    for (int k = 0; k < W; k++) if (x[k]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [W-1:0] rnd_bus();
    logic [159:0] t;
    t = {$urandom, $urandom, $urandom, $urandom, $urandom};
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] bit_at(input int k);
    logic [W-1:0] one;
    one = '0;
    one[k] = 1'b1;
    return one;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural model updated at every rising edge (R3: one cycle)
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_vote = '0; m_d0 = '0; m_d1 = '0; m_d2 = '0; m_req = '0;
    end else begin
      m_vote = ref_vote(l0, l1, l2);
      m_d0 = ref_diff(l0, m_vote);
      m_d1 = ref_diff(l1, m_vote);
      m_d2 = ref_diff(l2, m_vote);
      m_req = {any_set(m_d2), any_set(m_d1), any_set(m_d0)};
    end
    armed = 1'b1;
  end

  // Per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (armed) begin
      chk(voted == m_vote, "R2 voted bus", voted, m_vote);
      chk(d0 == m_d0, "R4 lane0 diff", d0, m_d0);
      chk(d1 == m_d1, "R4 lane1 diff", d1, m_d1);
      chk(d2 == m_d2, "R4 lane2 diff", d2, m_d2);
      chk(req == m_req, "R5 requests", W'(req), W'(m_req));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic drive(input logic [W-1:0] a, b, c);
    @(negedge clk);
    l0 = a; l1 = b; l2 = c;
  endtask

  initial begin
    logic [W-1:0] base;
    logic [W-1:0] prev;
    repeat (3) @(negedge clk);
    // R8: outputs zero after reset
    chk(voted == '0 && req == 3'b000 && d0 == '0, "R8 reset state", voted, '0);
    rst = 1'b0;

    // R9: all lanes equal
    base = rnd_bus();
    drive(base, base, base);
    @(negedge clk);
    chk(req == 3'b000, "R9 no request", W'(req), '0);
    chk(voted == base, "R9 voted equals lanes", voted, base);

    // R1: core-field bit on lane 1
    drive(base, base ^ bit_at(155), base);
    @(negedge clk);
    chk(req == 3'b010, "R1 core bit lane1 request", W'(req), W'(3'b010));
    chk(d1 == bit_at(155), "R1 core bit lane1 diff", d1, bit_at(155));

    // R1: system-field bit on lane 2
    drive(base, base, base ^ bit_at(0));
    @(negedge clk);
    chk(req == 3'b100, "R1 system bit lane2 request", W'(req), W'(3'b100));
    chk(voted == base, "R2 outvoted lane ignored", voted, base);

    // R7: each lane outvoted on a different bit
    drive(base ^ bit_at(3), base ^ bit_at(70), base ^ bit_at(150));
    @(negedge clk);
    chk(req == 3'b111, "R7 all three requested", W'(req), W'(3'b111));
    chk(voted == base, "R7 vote keeps majority", voted, base);

    // R6: single-cycle glitch on lane 0
    drive(base, base, base);
    drive(base ^ bit_at(40), base, base);
    drive(base, base, base);
    chk(req == 3'b001, "R6 glitch requested", W'(req), W'(3'b001));
    @(negedge clk);
    chk(req == 3'b000, "R6 request dropped", W'(req), '0);

    // R3: a new input is not visible before the next edge
    prev = voted;
    base = ~base;
    drive(base, base, base);
    chk(voted == prev, "R3 no early change", voted, prev);
    @(negedge clk);
    chk(voted == base, "R3 one-cycle result", voted, base);

    // R8: mid-run reset with disagreeing lanes
    drive(rnd_bus(), rnd_bus(), rnd_bus());
    rst = 1'b1;
    @(negedge clk);
    chk(voted == '0 && req == 3'b000 && d2 == '0, "R8 mid-run reset", voted, '0);
    rst = 1'b0;

    // Random traffic: mostly one faulty lane, sometimes arbitrary
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] b;
      int sel;
      b = rnd_bus();
      sel = $urandom_range(0, 4);
      case (sel)
        0: drive(b, b, b);
        1: drive(b ^ rnd_bus(), b, b);
        2: drive(b, b ^ rnd_bus(), b);
        3: drive(b, b, b ^ bit_at($urandom_range(0, W - 1)));
        default: drive(rnd_bus(), rnd_bus(), rnd_bus());
      endcase
    end
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule